// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block owns one 8-bit control register. Two of its bits are volatile enables: a general write enable and a second enable that arms register updates. The other five bits are retained settings: a 2-bit watchdog period select and a 3-bit block-protect code. The retained settings can only be changed through a fixed unlock sequence of three separate register write transactions. The last transaction starts a commit that keeps the block busy for a configurable number of clock cycles. The two enables change as soon as their transaction closes, with no busy period.

The block sits behind a serial-bus front end, which is not part of this design. The front end hands it decoded events: transaction open, one data byte tagged as register or array together with its 9-bit array address, transaction close, and register read strobes. For every data byte the block answers with an acknowledge or a refusal one cycle later. It decodes the block-protect code into a protected address region. It flags any address presented on a separate lookup port that falls inside that region. A register byte is held until the transaction closes and is applied only then. A read, or a second register byte, throws the held byte away.

Top module: `ctlreg_guard`

## Requirements
- R1: After reset the register reads 00h, `busy` is 0 and no address is reported protected.
- R2: While the write enable (bit 1) is 0, every data byte is refused (`ack_ok`=0) and has no effect. The one exception is the register byte 02h.
- R3: A register byte accepted alone in a transaction takes effect at close. 02h sets the write enable and 00h clears it. `busy` stays 0.
- R4: With the write enable set and the arm bit (bit 2) clear, the register byte 06h sets both bit 2 and bit 1.
- R5: With bit 2 set, a byte with bit 1=1, bit 2=0 and bit 5=0 starts a commit. `busy` is high for exactly COMMIT_CYCLES cycles. At the end, bits 7:6 (watchdog select) and the protect code are loaded from the byte, and bit 2 is cleared. The protect code is {bit 0, bit 4, bit 3}, most significant bit first. A read during `busy` returns the old value.
- R6: With bit 2 set, a byte with bits 2 and 1 both set leaves bit 2 set and changes no retained setting.
- R7: A second register byte in one transaction is refused, and the first is discarded.
- R8: A read strobe yields `rd_valid` one cycle later with the register in the layout {wd1, wd0, 0, bp1, bp0, arm, wen, bp2}. It ends any open transaction and discards a held byte. It does not disturb the unlock state.
- R9: While `busy` is 1, every data byte is refused.
- R10: The protected region, by code {bp2,bp1,bp0}, is:
  - 000: none
  - 001: 180h-1FFh
  - 010: 100h-1FFh
  - 011: all addresses
  - 100: 000h-00Fh
  - 101: 000h-01Fh
  - 110: 000h-03Fh
  - 111: 000h-07Fh
- R11: With the write enable set and not busy, an array byte is acknowledged. If its address is protected, the arm bit is cleared.
- R12: Every data byte strobe produces exactly one `ack_valid` pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, power-up state |
| txn_start | input | 1 | Opens a transaction |
| txn_stop | input | 1 | Closes a transaction; a held register byte is applied here |
| wr_valid | input | 1 | Data byte strobe |
| wr_is_reg | input | 1 | 1: byte targets the control register, 0: the array |
| wr_addr | input | ADDR_W | Array address of the byte |
| wr_data | input | 8 | Data byte |
| rd_strobe | input | 1 | Register read request; ends the transaction |
| ack_valid | output | 1 | Response to the previous cycle's byte is valid |
| ack_ok | output | 1 | 1: acknowledge, 0: refusal |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Register snapshot |
| busy | output | 1 | Retained-settings commit in progress |
| chk_addr | input | ADDR_W | Address to test against protection |
| chk_protected | output | 1 | `chk_addr` is inside the protected region |

## Verification
Several kinds of stimulus are applied, and each one separates a different fault. The full unlock sequence with a commit byte shows that the fields are remapped to the right positions and that the busy window has the right length. The same sequence with a hold byte (bit 2 set) shows that the hold path is distinct from the commit path. A byte 03h followed by a second byte shows that an abort really drops an otherwise valid commit. A read inside an open transaction shows that the read discards the held byte. Sweeping all eight protect codes over the region edge addresses exposes off-by-one and swapped-code errors in the decode.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  typedef struct packed {
    logic [1:0] wd;   // watchdog period select
    logic [2:0] bp;   // protect code {bp2, bp1, bp0}
  } nv_t;

  localparam logic [7:0] CMD_CLR  = 8'h00;
  localparam logic [7:0] CMD_WEN  = 8'h02;
  localparam logic [7:0] CMD_ARM  = 8'h06;

  // register image: {wd1, wd0, 0, bp1, bp0, arm, wen, bp2}
  function automatic logic [7:0] pack_ctl(nv_t nv, logic arm, logic wen);
    return {nv.wd, 1'b0, nv.bp[1], nv.bp[0], arm, wen, nv.bp[2]};
  endfunction

  function automatic nv_t unpack_nv(logic [7:0] b);
    nv_t r;
    r.wd = b[7:6];
    r.bp = {b[0], b[4], b[3]};
    return r;
  endfunction

  function automatic logic is_commit_byte(logic [7:0] b);
    return b[1] & ~b[2] & ~b[5];
  endfunction

endpackage

// File: rtl/ctlreg_protect_map.sv
module ctlreg_protect_map #(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [2:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // low regions scale as 1/32, 1/16, 1/8, 1/4 of the array
  localparam logic [ADDR_W:0] LOW_LIM0 = (ADDR_W+1)'(1) << (ADDR_W - 5);

  logic [ADDR_W:0] low_lim;

  always_comb begin
    low_lim = LOW_LIM0 << bp[1:0];
    unique case (bp)
      3'b000:  hit = 1'b0;
      3'b001:  hit = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
      3'b010:  hit = addr[ADDR_W-1];
      3'b011:  hit = 1'b1;
      default: hit = ({1'b0, addr} < low_lim);
    endcase
  end
endmodule

// File: rtl/ctlreg_commit_timer.sv
module ctlreg_commit_timer #(
  parameter int unsigned CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_TIMER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q) else $error("timer start");                 // R5
  AST_TIMER_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q) else $error("timer end");                                // R5
endmodule

// File: rtl/ctlreg_txn_track.sv
module ctlreg_txn_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open,
  input  logic       close,
  input  logic       reg_byte,
  input  logic       reg_take,
  input  logic [7:0] din,
  output logic       in_txn,
  output logic       reg_seen,
  output logic       pend_live,
  output logic [7:0] pend_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_txn    <= 1'b0;
      reg_seen  <= 1'b0;
      pend_live <= 1'b0;
      pend_byte <= '0;
    end else if (open) begin
      in_txn    <= 1'b1;
      reg_seen  <= 1'b0;
      pend_live <= 1'b0;
    end else if (close) begin
      in_txn    <= 1'b0;
      reg_seen  <= 1'b0;
      pend_live <= 1'b0;
    end else if (reg_byte) begin
      reg_seen <= 1'b1;
      if (!reg_seen && reg_take) begin
        pend_live <= 1'b1;
        pend_byte <= din;
      end else begin
        pend_live <= 1'b0;
      end
    end
  end

  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_byte && reg_seen && !open && !close) |=> !pend_live) else $error("abort"); // R7
  AST_CLOSE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !open) |=> !pend_live) else $error("close");                     // R8
endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
  import ctlreg_pkg::*;
#(
  parameter int unsigned ADDR_W        = 9,
  parameter int unsigned COMMIT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              txn_stop,
  input  logic              wr_valid,
  input  logic              wr_is_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_strobe,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_protected
);
  nv_t        nv_q, nv_hold;
  logic       wen_q, arm_q;
  logic       in_txn, reg_seen, pend_live;
  logic [7:0] pend_byte;
  logic       wr_hit_prot;

  // named internal events
  logic reg_byte, arr_byte, reg_ok, arr_ok;
  logic ev_abort, ev_prot_hit, ev_apply, ev_commit_start, ev_commit_done;

  assign reg_byte        = wr_valid & wr_is_reg & in_txn;
  assign arr_byte        = wr_valid & ~wr_is_reg & in_txn;
  assign ev_abort        = reg_byte & reg_seen;
  assign reg_ok          = reg_byte & ~reg_seen & ~busy & (wen_q | (wr_data == CMD_WEN));
  assign arr_ok          = arr_byte & ~busy & wen_q;
  assign ev_prot_hit     = arr_ok & wr_hit_prot;
  assign ev_apply        = txn_stop & in_txn & pend_live & ~busy;
  assign ev_commit_start = ev_apply & arm_q & is_commit_byte(pend_byte);

  ctlreg_txn_track u_txn (
    .clk       (clk),
    .rst_n     (rst_n),
    .open      (txn_start),
    .close     (txn_stop | rd_strobe),
    .reg_byte  (reg_byte),
    .reg_take  (reg_ok),
    .din       (wr_data),
    .in_txn    (in_txn),
    .reg_seen  (reg_seen),
    .pend_live (pend_live),
    .pend_byte (pend_byte)
  );

  ctlreg_commit_timer #(.CYCLES(COMMIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_commit_start),
    .busy  (busy),
    .done  (ev_commit_done)
  );

  ctlreg_protect_map #(.ADDR_W(ADDR_W)) u_map_wr (
    .bp   (nv_q.bp),
    .addr (wr_addr),
    .hit  (wr_hit_prot)
  );

  ctlreg_protect_map #(.ADDR_W(ADDR_W)) u_map_chk (
    .bp   (nv_q.bp),
    .addr (chk_addr),
    .hit  (chk_protected)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q      <= '0;
      nv_hold   <= '0;
      wen_q     <= 1'b0;
      arm_q     <= 1'b0;
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      ack_valid <= wr_valid;
      ack_ok    <= reg_ok | arr_ok;
      rd_valid  <= rd_strobe;
      if (rd_strobe) rd_data <= pack_ctl(nv_q, arm_q, wen_q);

      if (ev_commit_done) begin
        nv_q  <= nv_hold;
        arm_q <= 1'b0;
      end
      if (ev_prot_hit) arm_q <= 1'b0;

      if (ev_commit_start) nv_hold <= unpack_nv(pend_byte);

      if (ev_apply) begin
        if (pend_byte == CMD_CLR) begin
          wen_q <= 1'b0;
        end else if (!arm_q) begin
          if (pend_byte == CMD_WEN) begin
            wen_q <= 1'b1;
          end else if (pend_byte == CMD_ARM) begin
            wen_q <= 1'b1;
            arm_q <= 1'b1;
          end
        end
      end
    end
  end

  AST_NACK_WEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wen_q && !(wr_is_reg && wr_data == CMD_WEN)) |=> (ack_valid && !ack_ok))
    else $error("wen low");                                                      // R2
  AST_VOLATILE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_apply && !ev_commit_start) |=> !busy) else $error("volatile busy");      // R3
  AST_NV_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit_done |=> $stable(nv_q)) else $error("nv change");                 // R5
  AST_SECOND_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !ack_ok) else $error("second byte");                            // R7
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_valid) else $error("read timing");                          // R8
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> !ack_ok) else $error("busy nack");                    // R9
  AST_ARM_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arm_q) |-> $past(ev_commit_done || ev_prot_hit)) else $error("arm");   // R11
  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> ack_valid) else $error("ack timing");                           // R12
endmodule

// File: tb/ctlreg_guard_tb.sv
module ctlreg_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 9;
  localparam int CYC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          txn_start = 0, txn_stop = 0, wr_valid = 0, wr_is_reg = 0, rd_strobe = 0;
  logic [AW-1:0] wr_addr = '0, chk_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          ack_valid, ack_ok, rd_valid, busy, chk_protected;
  logic [7:0]    rd_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic  q_ack[$];
  string q_ack_tag[$];
  logic [7:0] q_rd[$];
  string q_rd_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlreg_guard #(.ADDR_W(AW), .COMMIT_CYCLES(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
    .wr_valid(wr_valid), .wr_is_reg(wr_is_reg), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .ack_valid(ack_valid), .ack_ok(ack_ok),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .chk_addr(chk_addr), .chk_protected(chk_protected));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as responses appear (R12: one per byte)
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      if (q_ack.size() == 0) check("R12 unexpected ack_valid", 1, 0);
      else check(q_ack_tag.pop_front(), ack_ok, q_ack.pop_front());
    end
    if (rst_n && rd_valid) begin
      if (q_rd.size() == 0) check("R8 unexpected rd_valid", 1, 0);
      else check(q_rd_tag.pop_front(), rd_data, q_rd.pop_front());
    end
  end

  task automatic open_t();  @(negedge clk) txn_start = 1; @(negedge clk) txn_start = 0; endtask
  task automatic close_t(); @(negedge clk) txn_stop = 1;  @(negedge clk) txn_stop = 0;  endtask

  task automatic put_byte(bit isreg, logic [AW-1:0] a, logic [7:0] d, bit exp, string tag);
    @(negedge clk);
    wr_valid = 1; wr_is_reg = isreg; wr_addr = a; wr_data = d;
    q_ack.push_back(exp); q_ack_tag.push_back(tag);
    @(negedge clk) wr_valid = 0;
  endtask

  task automatic rd_reg(logic [7:0] exp, string tag);
    @(negedge clk);
    rd_strobe = 1; q_rd.push_back(exp); q_rd_tag.push_back(tag);
    @(negedge clk) rd_strobe = 0;
  endtask

  task automatic reg_write(logic [7:0] d, bit exp, string tag);
    open_t(); put_byte(1, '0, d, exp, tag); close_t();
  endtask

  task automatic arr_write(logic [AW-1:0] a, bit exp, string tag);
    open_t(); put_byte(0, a, 8'hA5, exp, tag); close_t();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic bit exp_prot(logic [2:0] code, logic [AW-1:0] a);
    case (code)
      3'd1: return a >= 9'h180;
      3'd2: return a >= 9'h100;
      3'd3: return 1'b1;
      3'd4: return a <= 9'h00F;
      3'd5: return a <= 9'h01F;
      3'd6: return a <= 9'h03F;
      3'd7: return a <= 9'h07F;
      default: return 1'b0;
    endcase
  endfunction

  task automatic probe(logic [AW-1:0] a, bit exp, string tag);
    @(negedge clk) chk_addr = a;
    #1 check(tag, chk_protected, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [AW-1:0] pts[14] = '{9'h000, 9'h00F, 9'h010, 9'h01F, 9'h020, 9'h03F, 9'h040,
                               9'h07F, 9'h080, 9'h0FF, 9'h100, 9'h17F, 9'h180, 9'h1FF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 busy after reset", busy, 0);
    rd_reg(8'h00, "R1 reset read");
    probe(9'h000, 0, "R1 no protection 000");
    probe(9'h1FF, 0, "R1 no protection 1FF");

    // R2 write enable low
    reg_write(8'h06, 0, "R2 06h refused with wen=0");
    arr_write(9'h020, 0, "R2 array refused with wen=0");
    rd_reg(8'h00, "R2 no effect");

    // R3 volatile enable
    reg_write(8'h02, 1, "R3 02h acked");
    check("R3 no busy after 02h", busy, 0);
    rd_reg(8'h02, "R3 wen set");
    reg_write(8'h00, 1, "R3 00h acked");
    rd_reg(8'h00, "R3 wen cleared");
    reg_write(8'h02, 1, "R3 02h again");

    // R4 arm
    reg_write(8'h06, 1, "R4 06h acked");
    rd_reg(8'h06, "R4 arm+wen set");

    // R8 read inside a transaction discards held commit byte
    open_t(); put_byte(1, '0, 8'h02, 1, "R8 held byte acked");
    rd_reg(8'h06, "R8 read mid transaction");
    close_t();
    check("R8 no commit after read-closed txn", busy, 0);
    rd_reg(8'h06, "R8 state kept");

    // R6 hold byte
    reg_write(8'h0E, 1, "R6 hold byte acked");
    check("R6 no busy", busy, 0);
    rd_reg(8'h06, "R6 nothing changed, arm kept");

    // R7 second byte aborts
    open_t();
    put_byte(1, '0, 8'h03, 1, "R7 first byte acked");
    put_byte(1, '0, 8'h02, 0, "R7 second byte refused");
    close_t();
    check("R7 aborted, no busy", busy, 0);
    rd_reg(8'h06, "R7 state unchanged");

    // R5 commit: wd=10, code 001
    reg_write(8'h8A, 1, "R5 commit byte acked");
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R5 busy length", n, CYC);
    rd_reg(8'h8A, "R5 fields loaded, arm cleared");
    probe(9'h17F, 0, "R10 code1 17F");
    probe(9'h180, 1, "R10 code1 180");

    // R11 protected array write clears arm
    reg_write(8'h06, 1, "R11 re-arm");
    rd_reg(8'h8E, "R11 armed");
    arr_write(9'h1A0, 1, "R11 protected write acked");
    rd_reg(8'h8A, "R11 arm cleared");
    arr_write(9'h010, 1, "R11 open write acked");

    // R9 busy refusal, R5 read during busy
    reg_write(8'h06, 1, "R9 re-arm");
    reg_write(8'h43, 1, "R9 commit byte acked");
    check("R9 busy raised", busy, 1);
    rd_reg(8'h8E, "R5 old value during busy");
    open_t(); put_byte(1, '0, 8'h02, 0, "R9 reg byte refused while busy"); close_t();
    arr_write(9'h100, 0, "R9 array byte refused while busy");
    wait_idle();
    rd_reg(8'h43, "R5 second commit loaded");

    // R10 sweep every code
    for (int c = 0; c < 8; c++) begin
      logic [7:0] b;
      b = {2'b00, 1'b0, c[1], c[0], 1'b0, 1'b1, c[2]};
      reg_write(8'h06, 1, "R10 arm");
      reg_write(b, 1, "R10 commit code");
      wait_idle();
      rd_reg(b, "R10 code read back");
      for (int i = 0; i < 14; i++)
        probe(pts[i], exp_prot(c[2:0], pts[i]), $sformatf("R10 code %0d addr %0h", c, pts[i]));
    end

    repeat (3) @(negedge clk);
    check("R12 all responses seen", q_ack.size() + q_rd.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule